// File: doc/BRIEF.md
# Twelve-Phase Timepulse Generator with End-of-Cycle Hold

This block steps through the twelve timepulses T01 to T12 that make up one memory cycle. Exactly one pulse is active at a time, and each tick-enable pulse moves the active pulse on by one phase. After T12 the generator normally wraps back to T01, so surrounding logic can key its work to a fixed slot within each cycle.

Two control inputs change this progress. A hold request does not stop the cycle where it stands. The current cycle runs on to T12, and the generator then stays on T12 for as long as the request is high. A severe-fault jump input ignores the tick and sends the generator to T12 on the next clock edge from any phase, which cuts the running cycle short.

Reset places the generator on T12, so the first restart is handled in the end-of-cycle slot. The block drives a one-hot phase vector and an end-of-cycle flag that is high during T12. The inputs and outputs are plain control and status pins. They carry no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `phase_wheel`

## Requirements
- R1: While `rst_n` is low, `phase_vec` equals only bit PHASES-1 set (T12), and `cycle_end` is 1.
- R2: `phase_vec` has exactly one bit set at every clock edge after reset. Bit 0 is T01 and bit PHASES-1 is T12.
- R3: If the active bit i is below PHASES-1, and `tick` is 1 and `jump_end` is 0 at an edge, bit i+1 becomes the active bit.
- R4: If `tick` and `jump_end` are both 0 at an edge, `phase_vec` keeps its value.
- R5: On T12, with `tick` 1 and both `hold_req` and `jump_end` 0, the next edge makes bit 0 (T01) the active bit.
- R6: On T12, with `hold_req` 1, the generator stays on T12 whatever `tick` is.
- R7: `hold_req` has no effect before T12. A phase below PHASES-1 still advances on `tick`.
- R8: When `jump_end` is 1 at an edge, T12 becomes the active bit from any phase, whatever `tick` is.
- R9: When `jump_end` and `hold_req` are both 1, the generator moves to T12 and stays there while `hold_req` remains 1.
- R10: `cycle_end` is 1 exactly when T12 (bit PHASES-1) is the active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Step enable: one phase per high cycle |
| hold_req | input | 1 | Hold on T12 instead of wrapping to T01 |
| jump_end | input | 1 | Severe-fault jump straight to T12 |
| phase_vec | output | PHASES | One-hot timepulse vector; bit 0 = T01 |
| cycle_end | output | 1 | High during T12 |

## Verification
Directed runs cover several cases:
- A plain stepping sequence with gaps in `tick`, which separates advance from idle hold.
- A hold request raised mid-cycle, which shows that the hold waits for T12 rather than freezing the current phase.
- A jump taken from each phase with `tick` low, which shows that the jump does not depend on the step enable.
- A jump combined with a hold request, which shows that the generator stays on T12 afterwards.

Seeded random sequences of tick, hold and jump then mix every pair of conditions. Each cycle is compared with a bench model of the phase index.

// File: rtl/phase_wheel_pkg.sv
package phase_wheel_pkg;

  // Action chosen for the next clock edge.
  typedef enum logic [1:0] {
    ACT_STAY = 2'd0,  // keep the current phase
    ACT_STEP = 2'd1,  // move to the next phase
    ACT_WRAP = 2'd2,  // last phase back to the first
    ACT_JUMP = 2'd3   // go to the last phase at once
  } wheel_act_e;

endpackage

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_wheel_pkg::*;
(
  input  logic       tick,
  input  logic       hold_req,
  input  logic       jump_end,
  input  logic       at_last,
  output wheel_act_e act
);

  // Priority: jump, then idle, then hold-on-last, then wrap or step.
  always_comb begin
    if (jump_end)
      act = ACT_JUMP;
    else if (!tick)
      act = ACT_STAY;
    else if (at_last)
      act = hold_req ? ACT_STAY : ACT_WRAP;
    else
      act = ACT_STEP;
  end

endmodule

// File: rtl/phase_ring.sv
module phase_ring
  import phase_wheel_pkg::*;
#(
  parameter int PHASES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wheel_act_e        act,
  output logic [PHASES-1:0] ring_q
);

  localparam int LAST = PHASES - 1;

  logic [PHASES-1:0] ring_d;

  // Next-value logic, one slice per phase bit.
  for (genvar i = 0; i < PHASES; i++) begin : g_bit
    always_comb begin
      unique case (act)
        ACT_STEP: ring_d[i] = (i == 0) ? 1'b0 : ring_q[(i == 0) ? 0 : i-1];
        ACT_WRAP: ring_d[i] = (i == 0);
        ACT_JUMP: ring_d[i] = (i == LAST);
        default:  ring_d[i] = ring_q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ring_q[i] <= (i == LAST);
      else        ring_q[i] <= ring_d[i];
    end
  end

endmodule

// File: rtl/phase_wheel.sv
module phase_wheel
  import phase_wheel_pkg::*;
#(
  parameter int PHASES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_req,
  input  logic              jump_end,
  output logic [PHASES-1:0] phase_vec,
  output logic              cycle_end
);

  localparam int LAST = PHASES - 1;

  wheel_act_e act;
  logic       at_last;

  assign at_last = phase_vec[LAST];

  phase_step_ctrl i_ctrl (
    .tick     (tick),
    .hold_req (hold_req),
    .jump_end (jump_end),
    .at_last  (at_last),
    .act      (act)
  );

  phase_ring #(.PHASES(PHASES)) i_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .ring_q (phase_vec)
  );

  assign cycle_end = at_last;

endmodule

// File: rtl/phase_wheel_chk.sv
module phase_wheel_chk #(
  parameter int PHASES = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              hold_req,
  input logic              jump_end,
  input logic [PHASES-1:0] phase_vec,
  input logic              cycle_end
);

  localparam int LAST = PHASES - 1;

  a_r1_reset_last: assert property (@(posedge clk)
    !rst_n |=> phase_vec[LAST]);

  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_vec) == 1);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !jump_end && !phase_vec[LAST]) |=> phase_vec == ($past(phase_vec) << 1));

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !jump_end) |=> $stable(phase_vec));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold_req && !jump_end && phase_vec[LAST]) |=> phase_vec[0]);

  a_r6_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && phase_vec[LAST]) |=> phase_vec[LAST]);

  a_r8_jump: assert property (@(posedge clk) disable iff (!rst_n)
    jump_end |=> phase_vec[LAST]);

  a_r10_end_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_end) |-> ($past(tick) || $past(jump_end)));

endmodule

bind phase_wheel phase_wheel_chk #(.PHASES(PHASES)) i_phase_wheel_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .hold_req  (hold_req),
  .jump_end  (jump_end),
  .phase_vec (phase_vec),
  .cycle_end (cycle_end)
);

// File: tb/test_phase_wheel.sv
`timescale 1ns/1ps
module test_phase_wheel;

  localparam int PHASES = 12;
  localparam int LAST   = PHASES - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              hold_req = 1'b0;
  logic              jump_end = 1'b0;
  logic [PHASES-1:0] phase_vec;
  logic              cycle_end;

  int total = 0;
  int bad   = 0;
  int exp_idx = LAST;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  phase_wheel #(.PHASES(PHASES)) i_phase_wheel (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold_req  (hold_req),
    .jump_end  (jump_end),
    .phase_vec (phase_vec),
    .cycle_end (cycle_end)
  );

  function automatic int next_idx(int idx, bit t, bit s, bit f);
    if (f)             return LAST;
    if (!t)            return idx;
    if (idx == LAST)   return s ? LAST : 0;
    return idx + 1;
  endfunction

  function automatic string tag_for(int idx, bit t, bit s, bit f);
    if (f)           return s ? "R9" : "R8";
    if (!t)          return "R4";
    if (idx == LAST) return s ? "R6" : "R5";
    return s ? "R7" : "R3";
  endfunction

  function automatic logic [PHASES-1:0] vec_of(int idx);
    return {{(PHASES-1){1'b0}}, 1'b1} << idx;
  endfunction

  task automatic check_now(string tag);
    total++;
    if (phase_vec !== vec_of(exp_idx)) begin
      bad++;
      $display("FAIL %s/R2 phase_vec actual=%b expected=%b", tag, phase_vec, vec_of(exp_idx));
    end
    total++;
    if (cycle_end !== (exp_idx == LAST)) begin
      bad++;
      $display("FAIL R10 cycle_end actual=%b expected=%b", cycle_end, (exp_idx == LAST));
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(bit t, bit s, bit f);
    string tag;
    tag = tag_for(exp_idx, t, s, f);
    tick = t; hold_req = s; jump_end = f;
    exp_idx = next_idx(exp_idx, t, s, f);
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check_now("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R1");

    // R5 then R3 / R4: full cycle with gaps in tick
    for (int k = 0; k < 2 * PHASES; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);

    // R7: hold raised mid-cycle still advances to T12; R6: then stays
    while (exp_idx != 3) step(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < PHASES + 4; k++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);  // R5 wrap after hold released

    // R8: jump from every phase with tick low
    for (int p = 0; p < LAST; p++) begin
      while (exp_idx != p) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
    end

    // R9: jump with hold, then hold only keeps T12
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      bit t, s, f;
      t = ($urandom % 4) != 0;
      s = ($urandom % 4) == 0;
      f = ($urandom % 16) == 0;
      step(t, s, f);
    end

    // R1: reset again from mid-cycle
    while (exp_idx != 5) step(1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    exp_idx = LAST;
    #1;
    check_now("R1");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule